// File: doc/BRIEF.md
# XOR Crypto Slave Core Interface

This block sits between a slave pipeline and its storage so that nothing at rest is plaintext. A 64-bit symmetric key register, loaded by the master core, masks every word with a bitwise XOR. Instruction words are stored exactly as the master delivers them. They are unmasked with the low half of the key on the way to decode. Data-memory stores and register-file writebacks are masked on the way in and unmasked on the way out. The pipeline's execute logic sits outside this block and connects through plain request/response ports.

The master controls the slave through five commands. It loads the key, writes instruction words into the slave's instruction memory, and reads slave data memory in masked form. It also starts the slave, and it stops the slave, which returns the program counter, the fetch stage and the register file to their initial state. The key can only be replaced while the slave is stopped, so register contents can never be decrypted with a stale key.

Top module: `xor_slave_shell`

## Requirements
- R1: After reset the slave is stopped: `run_o`=0, `pc_o`=0, `if_valid_o`=0, both register read ports return 0, and the key is zero.
- R2: A key write while stopped replaces the key from the next cycle on. A key write while running has no effect on any later unmasked output.
- R3: While running, each cycle latches `if_instr_o` = imem[pc] XOR key[31:0], asserts `if_valid_o`, and advances `pc_o` by one, wrapping at the memory depth. The first fetch after start reads address 0.
- R4: `pc_load_i` while running latches the current fetch and loads `pc_o` with `pc_target_i`. The next fetch reads the target address.
- R5: A pipeline data store writes `dm_wdata_i` XOR key. `dm_rdata_o` returns the stored word XOR the current key (combinational read).
- R6: `mst_dmem_rdata_o` returns the stored, still-masked data-memory word at `mst_dmem_addr_i`.
- R7: A register-file write stores `rf_wdata_i` XOR key. Both read ports return the stored word XOR the key, and 0 for a register not written since reset or stop.
- R8: Pipeline data-memory and register-file writes are ignored while the slave is stopped.
- R9: `mst_stop_i` clears run, the program counter, fetch valid and every register, taking effect the next cycle. It wins over a simultaneous `mst_start_i`.
- R10: A master instruction write stores `mst_imem_wdata_i` unmodified at `mst_imem_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mst_key_we_i | input | 1 | Master key load strobe |
| mst_key_i | input | 64 | Key value to load |
| mst_imem_we_i | input | 1 | Master instruction-memory write strobe |
| mst_imem_addr_i | input | 6 | Instruction-memory write address |
| mst_imem_wdata_i | input | 32 | Masked instruction word |
| mst_dmem_addr_i | input | 6 | Master data-memory read address |
| mst_dmem_rdata_o | output | 64 | Masked data-memory word |
| mst_start_i | input | 1 | Start the slave |
| mst_stop_i | input | 1 | Stop and reset the slave |
| run_o | output | 1 | Slave running |
| pc_o | output | 6 | Slave program counter |
| if_valid_o | output | 1 | Fetch-stage word valid |
| if_instr_o | output | 32 | Unmasked instruction to decode |
| pc_load_i | input | 1 | Redirect request from pipeline |
| pc_target_i | input | 6 | Redirect target |
| rf_rs_addr_i | input | 4 | First register read address |
| rf_rt_addr_i | input | 4 | Second register read address |
| rf_rs_data_o | output | 64 | Unmasked first read value |
| rf_rt_data_o | output | 64 | Unmasked second read value |
| rf_we_i | input | 1 | Register writeback strobe |
| rf_waddr_i | input | 4 | Writeback register |
| rf_wdata_i | input | 64 | Plain writeback value |
| dm_we_i | input | 1 | Pipeline data store strobe |
| dm_addr_i | input | 6 | Pipeline data address (read and write) |
| dm_wdata_i | input | 64 | Plain store value |
| dm_rdata_o | output | 64 | Unmasked load value |

## Verification
Random instruction words are fetched under several keys. Only the correct key reproduces the stored words, so a missing or half-width unmask shows up at once. Random register and data writes are checked on both the plain pipeline ports and the masked master port. This separates a missing mask from a missing unmask, which a plain round trip alone cannot reveal. Directed cases cover key writes while running, redirects, writes while stopped, and start and stop in the same cycle. A final stored word read back after a key change shows that the new key is in use.

// File: rtl/xs_pkg.sv
package xs_pkg;
  parameter int unsigned KEY_W = 64;
  typedef logic [KEY_W-1:0] key_t;

  function automatic key_t xs_mask(input key_t v, input key_t k);
    return v ^ k;
  endfunction
endpackage

// File: rtl/xs_key_reg.sv
module xs_key_reg
  import xs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic we_i,
  input  key_t key_i,
  output key_t key_o
);
  key_t key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             key_q <= '0;
    else if (we_i && !run_i) key_q <= key_i;
  end

  assign key_o = key_q;

  AST_KEY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(key_q)) else $error("key changed while running"); // R2
endmodule

// File: rtl/xs_fetch.sv
module xs_fetch #(
  parameter int unsigned IW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [IW-1:0] key_lo_i,
  input  logic          imem_we_i,
  input  logic [AW-1:0] imem_addr_i,
  input  logic [IW-1:0] imem_wdata_i,
  input  logic          pc_load_i,
  input  logic [AW-1:0] pc_target_i,
  output logic          run_o,
  output logic [AW-1:0] pc_o,
  output logic          valid_o,
  output logic [IW-1:0] instr_o
);
  logic [IW-1:0] imem_q [DEPTH];
  logic          run_q, vld_q;
  logic [AW-1:0] pc_q;
  logic [IW-1:0] instr_q;

  // image stays masked; written verbatim
  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem_q[imem_addr_i] <= imem_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      pc_q    <= '0;
      vld_q   <= 1'b0;
      instr_q <= '0;
    end else if (stop_i) begin
      run_q   <= 1'b0;
      pc_q    <= '0;
      vld_q   <= 1'b0;
      instr_q <= '0;
    end else begin
      if (start_i) run_q <= 1'b1;
      vld_q <= run_q;
      if (run_q) begin
        instr_q <= imem_q[pc_q] ^ key_lo_i;
        pc_q    <= pc_load_i ? pc_target_i : pc_q + 1'b1;
      end
    end
  end

  assign run_o   = run_q;
  assign pc_o    = pc_q;
  assign valid_o = vld_q;
  assign instr_o = instr_q;

  AST_STOP_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (pc_q == '0 && !run_q && !vld_q)) else $error("stop ineffective"); // R9
  AST_IDLE_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !vld_q) else $error("fetch while stopped"); // R3
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !stop_i && !pc_load_i) |=> pc_q == AW'($past(pc_q) + 1'b1)) else $error("pc step"); // R3
  AST_PC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !stop_i && pc_load_i) |=> pc_q == $past(pc_target_i)) else $error("pc load"); // R4
endmodule

// File: rtl/xs_dmem.sv
module xs_dmem
  import xs_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          run_i,
  input  key_t          key_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  key_t          wdata_i,
  output key_t          rdata_o,
  input  logic [AW-1:0] mst_addr_i,
  output key_t          mst_rdata_o
);
  key_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && run_i) mem_q[addr_i] <= xs_mask(wdata_i, key_i);
  end

  assign rdata_o     = xs_mask(mem_q[addr_i], key_i);
  assign mst_rdata_o = mem_q[mst_addr_i];
endmodule

// File: rtl/xs_regfile.sv
module xs_regfile
  import xs_pkg::*;
#(
  parameter int unsigned NREG = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clear_i,
  input  key_t          key_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  key_t          wdata_i,
  input  logic [AW-1:0] rs_addr_i,
  input  logic [AW-1:0] rt_addr_i,
  output key_t          rs_data_o,
  output key_t          rt_data_o
);
  key_t            rf_q [NREG];
  logic [NREG-1:0] vld_q;

  // valid bits let a stop clear the file without re-masking under a future key
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rf_q[g]  <= '0;
        vld_q[g] <= 1'b0;
      end else if (clear_i) begin
        vld_q[g] <= 1'b0;
      end else if (run_i && we_i && waddr_i == AW'(g)) begin
        rf_q[g]  <= xs_mask(wdata_i, key_i);
        vld_q[g] <= 1'b1;
      end
    end
  end

  assign rs_data_o = vld_q[rs_addr_i] ? xs_mask(rf_q[rs_addr_i], key_i) : '0;
  assign rt_data_o = vld_q[rt_addr_i] ? xs_mask(rf_q[rt_addr_i], key_i) : '0;

  AST_RF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(vld_q)) else $error("rf written while stopped"); // R8
  AST_RF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> vld_q == '0) else $error("rf not cleared"); // R9
endmodule

// File: rtl/xor_slave_shell.sv
module xor_slave_shell
  import xs_pkg::*;
#(
  parameter int unsigned IW          = 32,
  parameter int unsigned IMEM_DEPTH  = 64,
  parameter int unsigned DMEM_DEPTH  = 64,
  parameter int unsigned NREG        = 16,
  localparam int unsigned IAW        = $clog2(IMEM_DEPTH),
  localparam int unsigned DAW        = $clog2(DMEM_DEPTH),
  localparam int unsigned RAW        = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mst_key_we_i,
  input  logic [KEY_W-1:0] mst_key_i,
  input  logic             mst_imem_we_i,
  input  logic [IAW-1:0]   mst_imem_addr_i,
  input  logic [IW-1:0]    mst_imem_wdata_i,
  input  logic [DAW-1:0]   mst_dmem_addr_i,
  output logic [KEY_W-1:0] mst_dmem_rdata_o,
  input  logic             mst_start_i,
  input  logic             mst_stop_i,
  output logic             run_o,
  output logic [IAW-1:0]   pc_o,
  output logic             if_valid_o,
  output logic [IW-1:0]    if_instr_o,
  input  logic             pc_load_i,
  input  logic [IAW-1:0]   pc_target_i,
  input  logic [RAW-1:0]   rf_rs_addr_i,
  input  logic [RAW-1:0]   rf_rt_addr_i,
  output logic [KEY_W-1:0] rf_rs_data_o,
  output logic [KEY_W-1:0] rf_rt_data_o,
  input  logic             rf_we_i,
  input  logic [RAW-1:0]   rf_waddr_i,
  input  logic [KEY_W-1:0] rf_wdata_i,
  input  logic             dm_we_i,
  input  logic [DAW-1:0]   dm_addr_i,
  input  logic [KEY_W-1:0] dm_wdata_i,
  output logic [KEY_W-1:0] dm_rdata_o
);
  key_t key;
  logic run;

  xs_key_reg u_key (
    .clk_i, .rst_ni, .run_i(run), .we_i(mst_key_we_i), .key_i(mst_key_i), .key_o(key)
  );

  xs_fetch #(.IW(IW), .DEPTH(IMEM_DEPTH)) u_fetch (
    .clk_i, .rst_ni,
    .start_i(mst_start_i), .stop_i(mst_stop_i), .key_lo_i(key[IW-1:0]),
    .imem_we_i(mst_imem_we_i), .imem_addr_i(mst_imem_addr_i), .imem_wdata_i(mst_imem_wdata_i),
    .pc_load_i, .pc_target_i,
    .run_o(run), .pc_o, .valid_o(if_valid_o), .instr_o(if_instr_o)
  );

  xs_dmem #(.DEPTH(DMEM_DEPTH)) u_dmem (
    .clk_i, .run_i(run), .key_i(key),
    .we_i(dm_we_i), .addr_i(dm_addr_i), .wdata_i(dm_wdata_i), .rdata_o(dm_rdata_o),
    .mst_addr_i(mst_dmem_addr_i), .mst_rdata_o(mst_dmem_rdata_o)
  );

  xs_regfile #(.NREG(NREG)) u_rf (
    .clk_i, .rst_ni, .run_i(run), .clear_i(mst_stop_i), .key_i(key),
    .we_i(rf_we_i), .waddr_i(rf_waddr_i), .wdata_i(rf_wdata_i),
    .rs_addr_i(rf_rs_addr_i), .rt_addr_i(rf_rt_addr_i),
    .rs_data_o(rf_rs_data_o), .rt_data_o(rf_rt_data_o)
  );

  assign run_o = run;
endmodule

// File: tb/sim_xor_slave_shell.sv
module sim_xor_slave_shell;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        mst_key_we_i = 0;
  logic [63:0] mst_key_i = '0;
  logic        mst_imem_we_i = 0;
  logic [5:0]  mst_imem_addr_i = '0;
  logic [31:0] mst_imem_wdata_i = '0;
  logic [5:0]  mst_dmem_addr_i = '0;
  logic [63:0] mst_dmem_rdata_o;
  logic        mst_start_i = 0, mst_stop_i = 0;
  logic        run_o, if_valid_o;
  logic [5:0]  pc_o;
  logic [31:0] if_instr_o;
  logic        pc_load_i = 0;
  logic [5:0]  pc_target_i = '0;
  logic [3:0]  rf_rs_addr_i = '0, rf_rt_addr_i = '0, rf_waddr_i = '0;
  logic [63:0] rf_rs_data_o, rf_rt_data_o, rf_wdata_i = '0;
  logic        rf_we_i = 0, dm_we_i = 0;
  logic [5:0]  dm_addr_i = '0;
  logic [63:0] dm_wdata_i = '0, dm_rdata_o;

  xor_slave_shell u0 (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_imem [16];
  logic [63:0] m_dmem [64];
  bit          m_dv [64];
  logic [63:0] m_rf [16];
  bit          m_rv [16];
  logic [63:0] k1, k2, k3;
  int          seed = 11;

  function automatic logic [63:0] f_enc(logic [63:0] v, logic [63:0] k);
    return v ^ k;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle_in();
    mst_key_we_i = 0; mst_imem_we_i = 0; mst_start_i = 0; mst_stop_i = 0;
    pc_load_i = 0; rf_we_i = 0; dm_we_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(seed));
    k1 = {$urandom, $urandom}; k2 = {$urandom, $urandom}; k3 = {$urandom, $urandom};
    foreach (m_dv[i]) m_dv[i] = 0;
    foreach (m_rv[i]) m_rv[i] = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    #1;
    // R1 reset state
    chk("R1 run", 64'(run_o), 0);
    chk("R1 pc", 64'(pc_o), 0);
    chk("R1 valid", 64'(if_valid_o), 0);
    chk("R1 rs", rf_rs_data_o, 0);
    @(negedge clk_i);

    // R2 load key while stopped
    mst_key_we_i = 1; mst_key_i = k1; tick(); idle_in();
    // R10 master writes instruction image
    for (int i = 0; i < 16; i++) begin
      mst_imem_we_i = 1; mst_imem_addr_i = 6'(i); mst_imem_wdata_i = $urandom;
      m_imem[i] = mst_imem_wdata_i; tick();
    end
    idle_in();
    mst_start_i = 1; tick(); idle_in();
    chk("R3 run after start", 64'(run_o), 1);
    chk("R3 pc at start", 64'(pc_o), 0);
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R3 R10 fetch word", 64'(if_instr_o), 64'(m_imem[i] ^ k1[31:0]));
      chk("R3 pc step", 64'(pc_o), 64'(i + 1));
      chk("R3 valid", 64'(if_valid_o), 1);
    end
    // R2 key write while running ignored
    mst_key_we_i = 1; mst_key_i = k2; tick(); idle_in();
    chk("R2 fetch during write", 64'(if_instr_o), 64'(m_imem[8] ^ k1[31:0]));
    tick();
    chk("R2 key kept", 64'(if_instr_o), 64'(m_imem[9] ^ k1[31:0]));
    // R4 redirect
    pc_load_i = 1; pc_target_i = 6'd3; tick(); idle_in();
    chk("R4 pc loaded", 64'(pc_o), 3);
    chk("R4 fetch at redirect", 64'(if_instr_o), 64'(m_imem[10] ^ k1[31:0]));
    tick();
    chk("R4 fetch target", 64'(if_instr_o), 64'(m_imem[3] ^ k1[31:0]));
    chk("R4 pc after target", 64'(pc_o), 4);

    // R5 R6 R7 random traffic
    for (int it = 0; it < 200; it++) begin
      int ra, da;
      ra = $urandom_range(15); da = $urandom_range(63);
      rf_we_i = 1; rf_waddr_i = 4'(ra); rf_wdata_i = {$urandom, $urandom};
      dm_we_i = 1; dm_addr_i = 6'(da); dm_wdata_i = {$urandom, $urandom};
      m_rf[ra] = rf_wdata_i; m_rv[ra] = 1;
      m_dmem[da] = f_enc(dm_wdata_i, k1); m_dv[da] = 1;
      tick(); idle_in();
      rf_rs_addr_i = 4'($urandom_range(15)); rf_rt_addr_i = 4'($urandom_range(15));
      dm_addr_i = 6'($urandom_range(63)); mst_dmem_addr_i = dm_addr_i;
      #1;
      chk("R7 rs", rf_rs_data_o, m_rv[rf_rs_addr_i] ? m_rf[rf_rs_addr_i] : 64'h0);
      chk("R7 rt", rf_rt_data_o, m_rv[rf_rt_addr_i] ? m_rf[rf_rt_addr_i] : 64'h0);
      if (m_dv[dm_addr_i]) begin
        chk("R5 load plain", dm_rdata_o, f_enc(m_dmem[dm_addr_i], k1));
        chk("R6 master masked", mst_dmem_rdata_o, m_dmem[dm_addr_i]);
      end
      @(negedge clk_i);
    end

    // R9 stop
    mst_stop_i = 1; tick(); idle_in();
    chk("R9 run", 64'(run_o), 0);
    chk("R9 pc", 64'(pc_o), 0);
    chk("R9 valid", 64'(if_valid_o), 0);
    for (int r = 0; r < 16; r++) begin
      rf_rs_addr_i = 4'(r); #1;
      chk("R9 rf cleared", rf_rs_data_o, 0);
    end
    // R8 writes while stopped ignored
    begin
      int a;
      a = 0;
      for (int i = 0; i < 64; i++) if (m_dv[i]) a = i;
      @(negedge clk_i);
      rf_we_i = 1; rf_waddr_i = 4'd2; rf_wdata_i = 64'hdead_beef_1234_5678;
      dm_we_i = 1; dm_addr_i = 6'(a); dm_wdata_i = 64'h0bad_f00d_cafe_0001;
      tick(); idle_in();
      rf_rs_addr_i = 4'd2; mst_dmem_addr_i = 6'(a); #1;
      chk("R8 rf write ignored", rf_rs_data_o, 0);
      chk("R8 dmem write ignored", mst_dmem_rdata_o, m_dmem[a]);
      chk("R5 load while stopped", dm_rdata_o, f_enc(m_dmem[a], k1));
      @(negedge clk_i);
      // R9 stop wins over start
      mst_stop_i = 1; mst_start_i = 1; tick(); idle_in();
      chk("R9 stop over start", 64'(run_o), 0);
      // R2 key change while stopped
      mst_key_we_i = 1; mst_key_i = k3; tick(); idle_in();
      dm_addr_i = 6'(a); #1;
      chk("R2 new key on load", dm_rdata_o, f_enc(m_dmem[a], k3));
      @(negedge clk_i);
    end
    mst_start_i = 1; tick(); idle_in();
    tick();
    chk("R2 new key on fetch", 64'(if_instr_o), 64'(m_imem[0] ^ k3[31:0]));
    rf_rs_addr_i = 4'd5; #1;
    chk("R7 unwritten after restart", rf_rs_data_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule